// File: doc/BRIEF.md
# I2C Serial Clock Bit Timer

This block produces the serial clock for a byte-oriented I2C master. It drives an open-drain SCL line only through a drive-low enable. A 16-bit compare word sets its timing. The low field is the half-period reload, counted in system clocks. The high field is the number of SCL output edges the frame may produce before the timer switches itself off. For a transfer of N bytes the high field is written as 18·N + 1: each byte has nine bit times, each bit time has two edges, and one more edge releases the line at the end. A high field of 1, which is a byte count of zero, is the way to request a plain stop after the last byte.

The timer starts while the trigger input is high. The trigger means transmit data has been loaded. The half-period counter only runs while the sensed SCL level agrees with the level the timer is trying to produce. A target that holds SCL low therefore stretches the high phase, and the high phase is timed from the moment the line is actually seen high. An abort mode replaces the edge-count limit: the frame ends on the first sensed SCL edge in either direction. The byte shifters and the transaction sequencing sit outside this block.

Top module: `scl_bit_timer`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and in the cycle after it, `active` is 0 and `scl_oe` is 0.
- R2: While idle and with `trig` low, `active` stays 0 and `scl_oe` stays 0, so the SCL line is released.
- R3: When `trig` is high in an idle cycle, `active` is 1 from the next cycle on. The timer output starts at logic zero, so `scl_oe` is 1 in that same cycle.
- R4: If the line is not stretched, every SCL phase (low or high) lasts LO+2 system clocks. LO is `cmp[7:0]`. One clock is for sensing the pin and one is for the counter reload.
- R5: In normal mode (`abort_mode` = 0) the frame lasts HI+1 phases, so `active` is high for (HI+1)·(LO+2) cycles. HI is `cmp[15:8]`. The low phases are the even-numbered ones counted from zero, so there are ceil((HI+1)/2) low pulses.
- R6: A high field of 1 (byte count zero) gives one low phase and then one released phase, and then the frame ends.
- R7: While the sensed SCL level differs from the timer output, the half-period counter is held at its reload value and the output does not toggle. A stretched high phase is longer by exactly the stretch time.
- R8: In abort mode the frame ends on the first sensed SCL edge. `active` falls two clocks after the line changes: one clock for sensing and one for the disable.
- R9: `scl_oe` is never 1 while `active` is 0. The line is released after every frame.
- R10: If `trig` is still high when a frame ends, `active` stays low for exactly one cycle and then the next frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Transmit data ready; starts a frame while idle |
| scl_in | input | 1 | Sensed level of the SCL line |
| cmp | input | 16 | Compare word: [15:8] edge limit, [7:0] half-period reload |
| abort_mode | input | 1 | 1 = end the frame on any sensed SCL edge; 0 = end it at the edge limit |
| scl_oe | output | 1 | Pull SCL low when 1; the line is never driven high |
| active | output | 1 | A frame is running |

## Verification
The hardest situation to reach from the ports is clock stretching. The stretch must begin exactly as the timer releases SCL, so that the held-low line is the only thing that delays the high phase. The bench closes the SCL loop by wiring the pin as the inverse of the drive-low enable, ORed with a bench-owned stretch signal. On the first sample where the enable has just dropped, the bench asserts the stretch signal and holds it for a fixed number of clocks. The measured frame length must then grow by exactly that number. Abort is applied at a chosen cycle in the middle of a frame, so that it lands between sensed edges. This shows the frame ends on the next real line edge rather than at once.

// File: rtl/scl_tmr_pkg.sv
package scl_tmr_pkg;

    localparam int unsigned DEF_FIELD_W    = 8;
    localparam int unsigned EDGES_PER_BYTE = 18;
    localparam int unsigned SENSE_OVERHEAD = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic level;
        logic chg;
    } scl_sense_t;

    // High compare field for a frame of the given number of bytes.
    function automatic int unsigned frame_edges(input int unsigned bytes);
        return bytes * EDGES_PER_BYTE + 1;
    endfunction

    // Low compare field for a wanted SCL rate, with the sensing overhead removed.
    function automatic int unsigned half_reload(input int unsigned src_hz,
                                                input int unsigned scl_hz);
        int unsigned half;
        half = (src_hz / scl_hz) / 2;
        return (half > SENSE_OVERHEAD) ? half - SENSE_OVERHEAD : 0;
    endfunction

endpackage

// File: rtl/scl_line_sense.sv
module scl_line_sense
    import scl_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    output scl_sense_t sense
);
    logic lvl_q;
    logic lvl_qq;

    // Both stages reset to the released (high) level of an idle bus.
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b1;
            lvl_qq <= 1'b1;
        end else begin
            lvl_q  <= scl_in;
            lvl_qq <= lvl_q;
        end
    end

    assign sense.level = lvl_q;
    assign sense.chg   = lvl_q ^ lvl_qq;

endmodule

// File: rtl/scl_half_timer.sv
module scl_half_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         match,
    input  logic [W-1:0] reload,
    output logic         expire
);
    logic [W-1:0] cnt;

    // Held at the reload value while stopped or while the pin disagrees.
    always_ff @(posedge clk) begin
        if (rst || !run || !match) begin
            cnt <= reload;
        end else if (cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = run && match && (cnt == '0);

endmodule

// File: rtl/scl_edge_tally.sv
module scl_edge_tally #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         reached
);
    logic [W-1:0] ecnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ecnt <= '0;
        end else if (step) begin
            ecnt <= ecnt + 1'b1;
        end
    end

    assign reached = (ecnt == limit);

    // R5: the edge count moves by at most one per cycle inside a frame.
    a_r5_edge_step: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (ecnt == $past(ecnt) || ecnt == $past(ecnt) + 1'b1));

endmodule

// File: rtl/scl_bit_timer.sv
module scl_bit_timer
    import scl_tmr_pkg::*;
#(
    parameter int unsigned FIELD_W = DEF_FIELD_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trig,
    input  logic                   scl_in,
    input  logic [2*FIELD_W-1:0]   cmp,
    input  logic                   abort_mode,
    output logic                   scl_oe,
    output logic                   active
);
    localparam int unsigned CMP_W = 2 * FIELD_W;

    tmr_state_e         state;
    logic               tout;
    scl_sense_t         sense;
    logic [FIELD_W-1:0] half_fld;
    logic [FIELD_W-1:0] edge_fld;
    logic               run;
    logic               match;
    logic               expire;
    logic               reached;
    logic               stop_now;
    logic               toggle;

    assign half_fld = cmp[FIELD_W-1:0];
    assign edge_fld = cmp[CMP_W-1:FIELD_W];
    assign run      = (state == ST_RUN);
    assign match    = (sense.level == tout);

    scl_line_sense u_sense (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sense  (sense)
    );

    scl_half_timer #(.W(FIELD_W)) u_half (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .match  (match),
        .reload (half_fld),
        .expire (expire)
    );

    scl_edge_tally #(.W(FIELD_W)) u_tally (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .step    (toggle),
        .limit   (edge_fld),
        .reached (reached)
    );

    // Abort mode: the sensed edge alone ends the frame. Normal mode: expiry at the edge limit.
    always_comb begin
        if (abort_mode) begin
            stop_now = run && sense.chg;
        end else begin
            stop_now = run && expire && reached;
        end
        toggle = run && expire && !stop_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tout  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (trig) begin
                        state <= ST_RUN;
                        tout  <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (stop_now) begin
                        state <= ST_IDLE;
                    end else if (toggle) begin
                        tout <= ~tout;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active = run;
    assign scl_oe = run && !tout;

    // R1: reset leaves the timer idle with the line released.
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!active && !scl_oe));

    // R3: a new frame begins with SCL pulled low.
    a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> scl_oe);

    // R7: no output toggle while the sensed pin disagrees with the output.
    a_r7_hold_mismatch: assert property (@(posedge clk) disable iff (rst)
        (run && (sense.level != tout)) |=> (tout == $past(tout)));

    // R8: in abort mode a sensed edge ends the frame in the next cycle.
    a_r8_abort_stop: assert property (@(posedge clk) disable iff (rst)
        (run && abort_mode && sense.chg) |=> !active);

endmodule

// File: tb/scl_bit_timer_tb_top.sv
module scl_bit_timer_tb_top;

    logic        clk;
    logic        rst;
    logic        trig;
    logic        scl_in;
    logic [15:0] cmp;
    logic        abort_mode;
    logic        scl_oe;
    logic        active;
    logic        stretch;

    int n_checks;
    int n_errors;
    int act_cnt;
    int oe_cnt;
    int pulse_cnt;
    logic oe_prev;
    logic mon_on;

    // Open-drain line: low when the timer or a stretching target pulls it.
    assign scl_in = ~(scl_oe | stretch);

    scl_bit_timer dut_i (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .scl_in     (scl_in),
        .cmp        (cmp),
        .abort_mode (abort_mode),
        .scl_oe     (scl_oe),
        .active     (active)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (mon_on) begin
            if (active) act_cnt = act_cnt + 1;
            if (scl_oe) oe_cnt = oe_cnt + 1;
            if (scl_oe && !oe_prev) pulse_cnt = pulse_cnt + 1;
        end
        oe_prev = scl_oe;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        act_cnt = 0;
        oe_cnt = 0;
        pulse_cnt = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!active) break;
        end
        @(negedge clk);
    endtask

    task automatic start_frame(input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        cmp  = {hi, lo};
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic t_reset();
        chk(!active, "R1 active after reset", active, 0);
        chk(!scl_oe, "R1 scl_oe after reset", scl_oe, 0);
    endtask

    task automatic t_idle();
        clear_counts();
        repeat (20) @(negedge clk);
        chk(act_cnt == 0, "R2 idle active count", act_cnt, 0);
        chk(oe_cnt == 0, "R2 idle scl_oe count", oe_cnt, 0);
    endtask

    task automatic t_one_byte();
        clear_counts();
        start_frame(8'd19, 8'd3);
        chk(active && scl_oe, "R3 first cycle active and low", {active, scl_oe}, 3);
        wait_idle();
        chk(act_cnt == 100, "R5 one-byte frame length", act_cnt, 100);
        chk(oe_cnt == 50, "R4 one-byte low time", oe_cnt, 50);
        chk(pulse_cnt == 10, "R5 one-byte low pulses", pulse_cnt, 10);
        chk(!scl_oe, "R9 line released after frame", scl_oe, 0);
    endtask

    task automatic t_zero_count();
        clear_counts();
        start_frame(8'd1, 8'd0);
        wait_idle();
        chk(act_cnt == 4, "R6 stop-only frame length", act_cnt, 4);
        chk(oe_cnt == 2, "R6 stop-only low time", oe_cnt, 2);
        chk(pulse_cnt == 1, "R6 stop-only pulses", pulse_cnt, 1);
    endtask

    task automatic t_two_bytes();
        clear_counts();
        start_frame(8'd37, 8'd5);
        wait_idle();
        chk(act_cnt == 266, "R5 two-byte frame length", act_cnt, 266);
        chk(oe_cnt == 133, "R4 two-byte low time", oe_cnt, 133);
        chk(pulse_cnt == 19, "R5 two-byte low pulses", pulse_cnt, 19);
    endtask

    task automatic t_stretch();
        logic seen_low;
        clear_counts();
        seen_low = 1'b0;
        start_frame(8'd3, 8'd2);
        for (int i = 0; i < 100; i++) begin
            if (scl_oe) seen_low = 1'b1;
            if (seen_low && !scl_oe) break;
            @(negedge clk);
        end
        stretch = 1'b1;
        repeat (3) @(negedge clk);
        chk(active && !scl_oe, "R7 held during stretch", {active, scl_oe}, 2);
        repeat (3) @(negedge clk);
        stretch = 1'b0;
        wait_idle();
        chk(act_cnt == 22, "R7 stretched frame length", act_cnt, 22);
        chk(oe_cnt == 8, "R7 stretched low time", oe_cnt, 8);
    endtask

    task automatic t_abort_start();
        clear_counts();
        abort_mode = 1'b1;
        start_frame(8'd19, 8'd3);
        wait_idle();
        abort_mode = 1'b0;
        chk(act_cnt == 2, "R8 abort on first edge", act_cnt, 2);
        chk(!scl_oe, "R9 released after abort", scl_oe, 0);
    endtask

    task automatic t_abort_mid();
        clear_counts();
        start_frame(8'd19, 8'd3);
        repeat (12) @(negedge clk);
        abort_mode = 1'b1;
        wait_idle();
        abort_mode = 1'b0;
        chk(act_cnt == 17, "R8 abort mid frame", act_cnt, 17);
    endtask

    task automatic t_retrigger();
        logic gap_seen;
        clear_counts();
        gap_seen = 1'b1;
        @(negedge clk);
        cmp  = {8'd1, 8'd0};
        trig = 1'b1;
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            if (i == 5) gap_seen = !active;
        end
        trig = 1'b0;
        wait_idle();
        chk(gap_seen, "R10 one idle cycle between frames", gap_seen, 1);
        chk(act_cnt == 8, "R10 back-to-back active cycles", act_cnt, 8);
    endtask

    initial begin
        #(20 * 200000);
        n_errors = n_errors + 1;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        n_checks   = 0;
        n_errors   = 0;
        mon_on     = 1'b0;
        oe_prev    = 1'b0;
        rst        = 1'b1;
        trig       = 1'b0;
        cmp        = 16'h0000;
        abort_mode = 1'b0;
        stretch    = 1'b0;
        clear_counts();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        t_reset();
        t_idle();
        t_one_byte();
        t_zero_count();
        t_two_bytes();
        t_stretch();
        t_abort_start();
        t_abort_mid();
        t_retrigger();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule